// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A single-cycle start request begins a conversion. The block first holds its track control high for a fixed number of cycles so that an external sample-and-hold stage can acquire the input. It then searches for the code one bit per clock, beginning with the most significant bit.

On each trial cycle the block presents a code to an external DAC and reads back one comparator bit. The bit is 1 when the held input is at least the DAC output. The block keeps the bit under test if the comparator reads 1 and clears it otherwise. It then raises the next lower bit as the new trial. After the least significant decision, the block stores the finished code as the result, pulses end-of-conversion for one cycle and goes back to idle.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, dac_code and result are all zero, and eoc and sample are low.
- R2: A start pulse seen in idle raises sample in the next cycle. Sample stays high for exactly SAMPLE_CYCLES cycles, and dac_code does not change while sample is high.
- R3: In the first cycle after sample falls, dac_code has only its most significant bit set (value 2^(WIDTH-1)).
- R4: On each trial clock the bit under test is kept when cmp_ge is 1 and cleared when cmp_ge is 0. The next lower bit becomes 1 in the same update.
- R5: A conversion takes exactly WIDTH trial cycles. eoc is high in the cycle that begins SAMPLE_CYCLES+WIDTH rising edges after the edge that accepted start.
- R6: While eoc is high, result equals dac_code, and both equal the largest code whose DAC value does not exceed the input.
- R7: eoc lasts one cycle. The block is then idle, with sample low, and it holds dac_code at the result.
- R8: result changes only in the cycle eoc rises. Through a later conversion it keeps the previous value until that conversion's eoc.
- R9: A start pulse during sampling or trials has no effect. The running conversion finishes on its original schedule, and no new sampling phase follows it.
- R10: An input of zero converts to all zeros. An input at or above full scale converts to all ones (2^WIDTH-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (honoured only when idle) |
| cmp_ge | input | 1 | Comparator: 1 when the held input is at least the DAC output |
| dac_code | output | WIDTH | Trial code driven to the external DAC |
| result | output | WIDTH | Last finished conversion |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| sample | output | 1 | High while the sample-and-hold stage tracks the input |

## Verification
The bench builds the block with WIDTH=6 and SAMPLE_CYCLES=2. At that width every one of the 64 input codes, plus one value beyond full scale, can be converted in a short run. This makes the search exhaustive across the whole range rather than sampled. The short sampling phase means a start request landing inside sampling and one landing inside the bit trials are both only a few cycles from the accepting edge, so the ignore rule is exercised in both phases.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH         = 8,
  parameter int SAMPLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result,
  output logic             eoc,
  output logic             sample
);

  localparam int CW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  typedef enum logic [1:0] {IDLE, TRACK, SEARCH} state_t;

  state_t           state_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] code_q, mask_q, result_q, decided;
  logic             eoc_q;

  assign decided  = cmp_ge ? code_q : (code_q & ~mask_q);
  assign dac_code = code_q;
  assign result   = result_q;
  assign eoc      = eoc_q;
  assign sample   = (state_q == TRACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= IDLE;
      cnt_q    <= '0;
      code_q   <= '0;
      mask_q   <= '0;
      result_q <= '0;
      eoc_q    <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      case (state_q)
        IDLE: begin
          if (start) begin
            state_q <= TRACK;
            cnt_q   <= '0;
          end
        end
        TRACK: begin
          if (cnt_q == CW'(SAMPLE_CYCLES - 1)) begin
            state_q <= SEARCH;
            code_q  <= TOP_BIT;
            mask_q  <= TOP_BIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEARCH: begin
          code_q <= decided | (mask_q >> 1);
          mask_q <= mask_q >> 1;
          if (mask_q[0]) begin
            result_q <= decided;
            eoc_q    <= 1'b1;
            state_q  <= IDLE;
          end
        end
        default: state_q <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] result,
  input logic             eoc,
  input logic             sample
);

  int trials;

  always_ff @(posedge clk) begin
    if (!rst_n)                trials <= 0;
    else if (sample)           trials <= 0;
    else if (trials <= WIDTH)  trials <= trials + 1;
  end

  AST_HOLD_CODE_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && $past(sample)) |-> $stable(dac_code)); // R2
  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample) |-> (dac_code == {1'b1, {(WIDTH-1){1'b0}}})); // R3
  AST_TRIAL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (trials == WIDTH)); // R5
  AST_RESULT_ON_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (result == dac_code)); // R6
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc); // R7
  AST_EOC_NOT_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoc && sample)); // R7
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result)); // R8

endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code),
  .result(result), .eoc(eoc), .sample(sample)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
  localparam int W    = 6;
  localparam int S    = 2;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  int           vin = 0;
  logic         cmp_ge;
  logic [W-1:0] dac_code, result;
  logic         eoc, sample;
  int           errs = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  assign cmp_ge = (vin >= int'(dac_code));

  sar_ctrl #(.WIDTH(W), .SAMPLE_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_ge(cmp_ge),
    .dac_code(dac_code), .result(result), .eoc(eoc), .sample(sample)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 dac_code", int'(dac_code), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 eoc", int'(eoc), 0);
    chk("R1 sample", int'(sample), 0);
  endtask

  // busy_at: cycle index (after the accepting edge) at which a stray start is driven, -1 for none
  task automatic run_conv(int v, int busy_at, string tag);
    int exp = (v > MAXV) ? MAXV : v;
    int prev_res = int'(result);
    int prev_code = int'(dac_code);
    vin = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c <= S + W; c++) begin
      if (c > 0) @(negedge clk);
      start = (c == busy_at);
      chk({tag, " R2 sample"}, int'(sample), int'(c < S));
      if (c < S) chk({tag, " R2 code held"}, int'(dac_code), prev_code);
      chk({tag, " R5 eoc timing"}, int'(eoc), int'(c == S + W));
      if (c == S) chk({tag, " R3 first trial"}, int'(dac_code), 1 << (W-1));
      if (c == S + 1)
        chk({tag, " R4 second trial"}, int'(dac_code),
            ((exp >> (W-1)) << (W-1)) | (1 << (W-2)));
      if (c < S + W) chk({tag, " R8 result held"}, int'(result), prev_res);
      if (c == S + W) begin
        chk({tag, " R6 result"}, int'(result), exp);
        chk({tag, " R6 dac_code"}, int'(dac_code), exp);
      end
    end
    @(negedge clk); start = 1'b0;
    chk({tag, " R7 eoc low"}, int'(eoc), 0);
    chk({tag, " R7 idle"}, int'(sample), 0);
    chk({tag, " R7 code kept"}, int'(dac_code), exp);
    @(negedge clk);
    chk({tag, " R9 no restart"}, int'(sample), 0);
    chk({tag, " R8 result kept"}, int'(result), exp);
  endtask

  task automatic test_sweep();
    for (int v = 0; v <= MAXV + 1; v++) run_conv(v, -1, "R6 sweep");
  endtask

  task automatic test_edges();
    run_conv(0, -1, "R10 zero");
    run_conv(MAXV + 20, -1, "R10 over");
    run_conv(MAXV, -1, "R10 full");
  endtask

  task automatic test_busy_start();
    run_conv(37, 0, "R9 start in sampling");
    run_conv(12, S + 2, "R9 start in trials");
    run_conv(50, S + W - 1, "R9 start at last trial");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_sweep();
    test_edges();
    test_busy_start();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule